// File: doc/BRIEF.md
# Remapped UART Register Front End

This block is the software-visible register file of a 16550-style serial port, with a register layout that departs from the classic byte map. Every register occupies its own 32-bit word, so word index n sits at byte address 4n, and software always accesses whole words. The line-control and modem-control bytes share one word. The FIFO-control byte shares a word with a spare character byte, which takes the place of the classic scratch register. The baud divisor has a word of its own, so no latch-select bit and no select sequence exist.

Behind the registers sit two 64-entry byte FIFOs. Writes to word 0 feed the transmit FIFO, which a serializer drains through a pop strobe. A deserializer fills the receive FIFO through a push strobe, and reads of word 0 drain it. The block decodes the bus access in the same cycle: read data is combinational, and side effects (push, pop, clear, overrun clear) take place at the clock edge that ends the access. The baud generator, the serializer and the deserializer live outside and see only the divisor, line-control, modem-control and FIFO handshake ports.

Each FIFO is controlled by a three-state machine: EMPTY, PARTIAL and FULL. An accepted push moves EMPTY to PARTIAL. A push that leaves PARTIAL with no free entry moves it to FULL. A pop moves FULL back to PARTIAL. A pop of the last entry moves PARTIAL to EMPTY. A clear returns any state to EMPTY. A simultaneous push and pop keeps the state.

Top module: `sio_regbank`

## Requirements
- R1: Word index is byte address bits above bit 1. Indices 6, 7, 8 and 10 to 15 read as 0, and writes to them (and writes to the read-only words 2 and 5) change no register and no FIFO. Upper bits not listed below read as 0.
- R2: Word 3 write stores bits 15:8 as the character byte and bit 0 as the FIFO-enable flag. A read of word 3 returns the character byte in bits 15:8 and 0 elsewhere.
- R3: Word 4 holds the modem-control byte in bits 7:0 and the line-control byte in bits 15:8, and one write sets both. Line-control bit 7 (word bit 15) is never stored: it reads as 0, and `lcr_o` and `mcr_o` present the stored bytes.
- R4: Word 9 holds the divisor (DIV_W bits, reset 0), which is written and read directly and driven on `div_o`.
- R5: A write to word 0 pushes bits 7:0 into the transmit FIFO unless it holds 64 entries, in which case the byte is dropped. `tx_avail` is 1 while the FIFO is non-empty, `tx_data` shows the oldest byte, and `tx_pop` removes it, in write order.
- R6: A read of word 0 returns the oldest receive byte in bits 7:0 and removes it. On an empty receive FIFO it returns 0 and has no effect. `rx_push` stores `rx_data` in arrival order.
- R7: A word 3 write with bit 1 set empties the receive FIFO, and one with bit 2 set empties the transmit FIFO. Neither bit is stored.
- R8: Word 5 reads line status: bit 0 = receive FIFO non-empty, bit 5 and bit 6 = transmit FIFO empty, bit 1 = overrun. Overrun is set by `rx_push` while the receive FIFO holds 64 entries (the byte is dropped), and it is cleared by a read of word 5. A new overrun in the same cycle wins.
- R9: Word 1 holds interrupt enables in bits 2:0 (bit 0 receive data, bit 1 transmit empty, bit 2 line status). Word 2 reads interrupt identification: 0x06 when overrun and bit 2 are set, else 0x04 when data is ready and bit 0 is set, else 0x02 when the transmit FIFO is empty and bit 1 is set, else 0x01. Bits 7:6 are both set when FIFO-enable is 1. `irq_o` is 1 exactly when bit 0 of that value is 0.
- R10: After reset every stored register is 0 and both FIFOs are empty, so line status reads 0x60 and identification reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word index in bits above bit 1 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_data | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit FIFO non-empty |
| tx_pop | input | 1 | Serializer takes the oldest transmit byte |
| rx_data | input | 8 | Received byte |
| rx_push | input | 1 | Deserializer delivers `rx_data` |
| lcr_o | output | 8 | Stored line-control byte |
| mcr_o | output | 8 | Stored modem-control byte |
| div_o | output | DIV_W | Baud divisor |
| irq_o | output | 1 | Interrupt request |

## Verification
The character byte and the line/modem pair are swept over all 256 byte values, with complementary and saturated patterns in the neighbouring fields, so that the two halves of a shared word are kept apart and the dropped line-control bit 7 shows up. The divisor takes walking-one values across all 32 bus bits, which separates the stored width from the ignored upper bits. Both FIFOs are run past their 64-entry limit with index-derived byte patterns, which exposes ordering faults, an off-by-one at the limit, and the overrun set/clear. The identification word is checked for all eight enable combinations in three pending-condition states, which covers the priority order.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [1:0] {
        FIFO_EMPTY   = 2'd0,
        FIFO_PARTIAL = 2'd1,
        FIFO_FULL    = 2'd2
    } fifo_state_e;

    localparam logic [31:0] WIDX_DATA = 32'd0;
    localparam logic [31:0] WIDX_IEN  = 32'd1;
    localparam logic [31:0] WIDX_IID  = 32'd2;
    localparam logic [31:0] WIDX_FCHR = 32'd3;
    localparam logic [31:0] WIDX_LNMD = 32'd4;
    localparam logic [31:0] WIDX_LST  = 32'd5;
    localparam logic [31:0] WIDX_DIV  = 32'd9;

endpackage

// File: rtl/sio_fifo.sv
module sio_fifo
    import sio_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_TOP  = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_NEAR = CW'(DEPTH - 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    fifo_state_e state_q, state_d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]    count_q;
    logic             push_ok, pop_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FIFO_EMPTY;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = FIFO_EMPTY;
        end else begin
            unique case (state_q)
                FIFO_EMPTY:   if (push_ok) state_d = FIFO_PARTIAL;
                FIFO_PARTIAL: begin
                    if (push_ok && !pop_ok && count_q == CNT_NEAR) state_d = FIFO_FULL;
                    else if (pop_ok && !push_ok && count_q == CW'(1)) state_d = FIFO_EMPTY;
                end
                FIFO_FULL:    if (pop_ok && !push_ok) state_d = FIFO_PARTIAL;
                default:      state_d = FIFO_EMPTY;
            endcase
        end
    end

    // outputs
    always_comb begin
        empty = (state_q == FIFO_EMPTY);
        full  = (state_q == FIFO_FULL);
        head  = mem[rd_ptr_q];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else if (clr) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (pop_ok)  rd_ptr_q <= ptr_next(rd_ptr_q);
            if (push_ok && !pop_ok)      count_q <= count_q + 1'b1;
            else if (pop_ok && !push_ok) count_q <= count_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr_q] <= wdata;
    end

    assert_level_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FIFO_EMPTY) == (count_q == '0));
    assert_level_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FIFO_FULL) == (count_q == CNT_TOP));
    assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FIFO_FULL && push && !pop && !clr) |=> (state_q == FIFO_FULL && $stable(wr_ptr_q)));
    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == FIFO_EMPTY));
endmodule

// File: rtl/sio_irqsel.sv
module sio_irqsel (
    input  logic [2:0] ien,
    input  logic       overrun,
    input  logic       data_rdy,
    input  logic       tx_empty,
    input  logic       fifo_en,
    output logic [7:0] iid,
    output logic       irq
);
    logic [2:0] code;
    logic       pend;

    always_comb begin
        pend = 1'b1;
        if (overrun && ien[2])       code = 3'b011;
        else if (data_rdy && ien[0]) code = 3'b010;
        else if (tx_empty && ien[1]) code = 3'b001;
        else begin
            code = 3'b000;
            pend = 1'b0;
        end
        iid = {fifo_en, fifo_en, 2'b00, code, !pend};
        irq = pend;
    end
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
    import sio_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DIV_W  = 16,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_avail,
    input  logic              tx_pop,
    input  logic [7:0]        rx_data,
    input  logic              rx_push,
    output logic [7:0]        lcr_o,
    output logic [7:0]        mcr_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              irq_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic [31:0]      widx;
    logic             wr_hit, rd_hit;
    logic [2:0]       ien_q;
    logic             fen_q;
    logic [7:0]       chr_q, lcr_q, mcr_q;
    logic [DIV_W-1:0] div_q;
    logic             oe_q;
    logic             tx_push, tx_clr, tx_empty, tx_full;
    logic             rx_pop, rx_clr, rx_empty, rx_full;
    logic [7:0]       rx_head, lst, iid;
    logic             unused_bits;

    assign widx   = 32'(bus_addr[ADDR_W-1:2]);
    assign wr_hit = bus_sel && bus_wr;
    assign rd_hit = bus_sel && !bus_wr;

    assign tx_push = wr_hit && widx == WIDX_DATA;
    assign rx_pop  = rd_hit && widx == WIDX_DATA;
    assign rx_clr  = wr_hit && widx == WIDX_FCHR && bus_wdata[1];
    assign tx_clr  = wr_hit && widx == WIDX_FCHR && bus_wdata[2];
    assign unused_bits = ^{bus_wdata[31:16], bus_addr[1:0], IDX_W[0]};

    sio_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push),
        .wdata(bus_wdata[7:0]), .pop(tx_pop), .head(tx_data),
        .empty(tx_empty), .full(tx_full)
    );

    sio_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push),
        .wdata(rx_data), .pop(rx_pop), .head(rx_head),
        .empty(rx_empty), .full(rx_full)
    );

    sio_irqsel u_irq (
        .ien(ien_q), .overrun(oe_q), .data_rdy(!rx_empty), .tx_empty(tx_empty),
        .fifo_en(fen_q), .iid(iid), .irq(irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
            fen_q <= 1'b0;
            chr_q <= '0;
            lcr_q <= '0;
            mcr_q <= '0;
            div_q <= '0;
        end else if (wr_hit) begin
            unique case (widx)
                WIDX_IEN:  ien_q <= bus_wdata[2:0];
                WIDX_FCHR: begin
                    fen_q <= bus_wdata[0];
                    chr_q <= bus_wdata[15:8];
                end
                WIDX_LNMD: begin
                    lcr_q <= {1'b0, bus_wdata[14:8]};
                    mcr_q <= bus_wdata[7:0];
                end
                WIDX_DIV:  div_q <= bus_wdata[DIV_W-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          oe_q <= 1'b0;
        else if (rx_push && rx_full)         oe_q <= 1'b1;
        else if (rd_hit && widx == WIDX_LST) oe_q <= 1'b0;
    end

    assign lst = {1'b0, tx_empty, tx_empty, 3'b000, oe_q, !rx_empty};

    always_comb begin
        unique case (widx)
            WIDX_DATA: bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
            WIDX_IEN:  bus_rdata = {29'd0, ien_q};
            WIDX_IID:  bus_rdata = {24'd0, iid};
            WIDX_FCHR: bus_rdata = {16'd0, chr_q, 8'd0};
            WIDX_LNMD: bus_rdata = {16'd0, lcr_q, mcr_q};
            WIDX_LST:  bus_rdata = {24'd0, lst};
            WIDX_DIV:  bus_rdata = 32'(div_q);
            default:   bus_rdata = 32'd0;
        endcase
    end

    assign tx_avail = !tx_empty;
    assign lcr_o    = lcr_q;
    assign mcr_o    = mcr_q;
    assign div_o    = div_q;

    assert_line_pack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && widx == WIDX_LNMD) |=>
            (lcr_o == {1'b0, $past(bus_wdata[14:8])} && mcr_o == $past(bus_wdata[7:0])));
    assert_div_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && widx == WIDX_DIV) |=> (div_o == $past(bus_wdata[DIV_W-1:0])));
    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> oe_q);
    assert_iid_lsr_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_q && ien_q[2]) |-> (iid[3:0] == 4'h6 && irq_o));
endmodule

// File: tb/sio_regbank_tb.sv
`timescale 1ns/1ps
module sio_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_data, rx_data = '0, lcr_o, mcr_o;
    logic        tx_avail, tx_pop = 1'b0, rx_push = 1'b0, irq_o;
    logic [15:0] div_o;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sio_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_data(tx_data), .tx_avail(tx_avail), .tx_pop(tx_pop),
        .rx_data(rx_data), .rx_push(rx_push), .lcr_o(lcr_o), .mcr_o(mcr_o),
        .div_o(div_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks enter and leave at a falling edge
    task automatic wr(input int idx, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = 6'(idx * 4); bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = 6'(idx * 4);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rdchk(input string req, input int idx, input logic [31:0] exp);
        logic [31:0] v;
        rd(idx, v);
        check(req, v, exp);
    endtask

    task automatic rxpush(input logic [7:0] d);
        rx_push = 1; rx_data = d;
        @(negedge clk);
        rx_push = 0;
    endtask

    task automatic txpop();
        tx_pop = 1;
        @(negedge clk);
        tx_pop = 0;
    endtask

    function automatic logic [7:0] iid_model(input logic [2:0] ien, input bit oe, input bit dr,
                                             input bit te, input bit fen);
        logic [7:0] b;
        b = fen ? 8'hC0 : 8'h00;
        if (oe && ien[2])      return b | 8'h06;
        else if (dr && ien[0]) return b | 8'h04;
        else if (te && ien[1]) return b | 8'h02;
        return b | 8'h01;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] chr_exp;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10 reset state
        for (int i = 0; i < 16; i++) begin
            logic [31:0] e;
            e = (i == 5) ? 32'h60 : (i == 2) ? 32'h01 : 32'h0;
            rdchk("R10", i, e);
        end
        check("R10 outputs", {tx_avail, irq_o, lcr_o, mcr_o, div_o}, 34'h0);

        // R2 character byte sweep
        for (int c = 0; c < 256; c++) begin
            wr(3, {16'hFFFF, 8'(c), 8'h01});
            rdchk("R2", 3, {16'h0, 8'(c), 8'h00});
        end
        chr_exp = 8'hFF;

        // R3 line/modem pair sweep
        for (int c = 0; c < 256; c++) begin
            wr(4, {16'hFFFF, 8'(c), ~8'(c)});
            rdchk("R3", 4, {16'h0, 8'(c) & 8'h7F, ~8'(c)});
            check("R3 pins", {lcr_o, mcr_o}, {8'(c) & 8'h7F, ~8'(c)});
        end

        // R4 divisor walking ones
        for (int b = 0; b < 32; b++) begin
            logic [31:0] w;
            w = 32'h1 << b;
            wr(9, w);
            rdchk("R4", 9, w & 32'hFFFF);
            check("R4 div_o", {16'h0, div_o}, w & 32'hFFFF);
        end
        wr(9, 32'h1234_A5C3);
        rdchk("R4", 9, 32'hA5C3);

        // R1 unmapped and read-only words ignore writes
        rxpush(8'h5A);
        for (int i = 6; i < 16; i++) if (i != 9) wr(i, 32'hFFFF_FFFF);
        wr(2, 32'h0000_0006);
        wr(5, 32'hFFFF_FFFF);
        for (int i = 6; i < 16; i++) if (i != 9) rdchk("R1", i, 32'h0);
        rdchk("R1 div kept", 9, 32'hA5C3);
        rdchk("R1 chr kept", 3, {16'h0, chr_exp, 8'h0});
        rdchk("R1 lcr kept", 4, 32'h7F00);
        rdchk("R1 rx kept", 5, 32'h61);
        rdchk("R6 pop", 0, 32'h5A);
        rdchk("R6 empty", 0, 32'h0);
        rdchk("R6 lsr", 5, 32'h60);

        // R5 transmit fill beyond limit, drain in order
        for (int i = 0; i < 66; i++) wr(0, {24'hABCDEF, 8'((i * 5 + 1) & 255)});
        check("R5 avail", {31'h0, tx_avail}, 32'h1);
        rdchk("R5 lsr nonempty", 5, 32'h00);
        for (int i = 0; i < 64; i++) begin
            check("R5 order", {24'h0, tx_data}, 32'((i * 5 + 1) & 255));
            txpop();
        end
        check("R5 drained", {31'h0, tx_avail}, 32'h0);
        rdchk("R5 lsr empty", 5, 32'h60);

        // R6 / R8 receive fill plus overrun
        for (int i = 0; i < 64; i++) rxpush(8'((i * 7 + 3) & 255));
        rdchk("R8 full no oe", 5, 32'h61);
        rxpush(8'hEE);
        rdchk("R8 oe set", 5, 32'h63);
        rdchk("R8 oe cleared", 5, 32'h61);
        for (int i = 0; i < 64; i++) rdchk("R6 order", 0, 32'((i * 7 + 3) & 255));
        rdchk("R6 after drain", 0, 32'h0);
        rdchk("R8 dr low", 5, 32'h60);

        // R7 selective clears
        rxpush(8'h11); rxpush(8'h22);
        wr(0, 32'h33);
        wr(3, {16'h0, chr_exp, 8'h02});
        rdchk("R7 rx cleared tx kept", 5, 32'h00);
        rdchk("R7 fcr reads 0", 3, {16'h0, chr_exp, 8'h0});
        check("R7 tx kept", {24'h0, tx_data}, 32'h33);
        wr(3, {16'h0, chr_exp, 8'h04});
        rdchk("R7 tx cleared", 5, 32'h60);
        check("R7 tx avail", {31'h0, tx_avail}, 32'h0);

        // R9 identification over enables and pending states
        wr(3, {16'h0, chr_exp, 8'h01});
        for (int e = 0; e < 8; e++) begin
            wr(1, 32'hFFFF_FFF8 | 32'(e));
            rdchk("R9 ien", 1, 32'(e));
            rdchk("R9 idle", 2, 32'(iid_model(3'(e), 0, 0, 1, 1)));
            check("R9 irq idle", {31'h0, irq_o}, {31'h0, ~iid_model(3'(e), 0, 0, 1, 1)}[0]);
        end
        wr(0, 32'h44);
        rxpush(8'h55);
        for (int e = 0; e < 8; e++) begin
            wr(1, 32'(e));
            rdchk("R9 data", 2, 32'(iid_model(3'(e), 0, 1, 0, 1)));
        end
        for (int i = 0; i < 64; i++) rxpush(8'h66);
        wr(3, {16'h0, chr_exp, 8'h00});
        for (int e = 0; e < 8; e++) begin
            wr(1, 32'(e));
            rdchk("R9 overrun", 2, 32'(iid_model(3'(e), 1, 1, 0, 0)));
            check("R9 irq", {31'h0, irq_o}, {31'h0, ~iid_model(3'(e), 1, 1, 0, 0)}[0]);
        end
        rd(5, v);
        check("R8 lsr oe", v, 32'h03);
        rdchk("R9 after oe clear", 2, 32'(iid_model(3'd7, 0, 1, 0, 0)));

        finish_run();
    end
endmodule